// File: doc/BRIEF.md
# Dual-Channel Phase-Correct PWM Timer

This block is a symmetric PWM generator. A single counter ramps up from zero to a ceiling and back down to zero, over and over. Two compare channels watch that ramp. Each channel changes its output pin when the ramp arrives at the channel's compare value. The change depends on whether the ramp is rising or falling, so each pulse stays centred on the counter's zero point.

Software picks one of three ceilings, for 8, 9 or 10 bits of resolution. It also gives each channel a mode: disconnected, non-inverted or inverted. Compare values are written at any time. A write first goes into a holding register. The value becomes active only when the counter arrives at its ceiling, so a write that does not line up with the counter can never produce a pulse of odd length.

The counter moves only on cycles where an external prescaler supplies a count tick. A separate flag says whether that prescaler is dividing the clock. The flag matters when the compare value equals the ceiling:
- Without division, the rising match and the falling match happen together and cancel, so the output never changes.
- With division, the two actions alternate on successive arrivals at the ceiling, which gives a pulse one whole period long.

Top module: `dual_pwm_timer`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) sets the following after that edge:
  - `count` to 0;
  - `counting_down` to 0;
  - both PWM outputs low;
  - both the holding and the active compare registers of each channel to 0.
- R2: The ceiling value depends on `res_sel`:
  - 00 gives 255;
  - 01 gives 511;
  - 10 and 11 give 1023.
- R3: Counter sequence:
  - The counter climbs by one per tick from 0 to the ceiling, then falls by one per tick back to 0, so it repeats every 2 × ceiling ticks.
  - `counting_down` becomes 1 on the tick that reaches the ceiling and 0 on the tick that reaches 0.
- R4: On a clock edge where `cnt_tick` is low, `count` and `counting_down` do not change.
- R5: Mode field encoding:
  - Mode 00 or 01 disconnects a channel: its PWM output stays low and its `oe` output is 0.
  - Mode 10 or 11 sets `oe` to 1.
- R6: Mode 10 (non-inverted), with the active compare value C strictly between 0 and the ceiling T:
  - the output clears when a rising count reaches C;
  - the output sets when a falling count reaches C;
  - so it is high for 2·C ticks of every 2·T-tick period.
- R7: Mode 11 (inverted), with the same C and T as R6:
  - the output sets when a rising count reaches C;
  - the output clears when a falling count reaches C;
  - so it is high for 2·(T−C) ticks per period.
- R8: A compare write (the `wr_x` strobe with its data) goes into the channel's holding register. It is copied into the active register only on the tick that brings the counter to the ceiling. At that tick the newly copied value is the one compared.
- R9: With `prescaled` = 0 and the active compare value equal to the ceiling, a connected channel's output never changes.
- R10: With `prescaled` = 1 and the active compare value equal to the ceiling, each arrival at the ceiling applies the next action of an alternating pair:
  - the first arrival applies the rising-count action (clear for mode 10, set for mode 11);
  - the next arrival applies the falling-count action;
  - so the output period is 4·T ticks and the output is high for 2·T of them.
- R11: Before comparison, the active compare value is masked to the selected resolution, so bits at or above the resolution width have no effect.
- R12: Each channel follows only its own mode and compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick | input | 1 | Count enable from the external prescaler |
| prescaled | input | 1 | High when the prescaler divides the clock |
| res_sel | input | 2 | Resolution select: 00 = 8-bit, 01 = 9-bit, 1x = 10-bit |
| mode_a | input | 2 | Channel A mode field |
| mode_b | input | 2 | Channel B mode field |
| wr_a | input | 1 | Write strobe for the channel A compare value |
| wr_b | input | 1 | Write strobe for the channel B compare value |
| data_a | input | CNT_W | Channel A compare write data |
| data_b | input | CNT_W | Channel B compare write data |
| pwm_a | output | 1 | Channel A PWM output |
| pwm_b | output | 1 | Channel B PWM output |
| oe_a | output | 1 | Channel A output enable |
| oe_b | output | 1 | Channel B output enable |
| count | output | CNT_W | Current counter value |
| counting_down | output | 1 | 1 while the counter is descending |

## Verification
The bench writes a new compare value partway up the ramp and then samples the output at two points:
- A design that applied the write at once would keep the output high past the old compare point on the rising slope.
- A design that never reloaded would miss the new set point on the falling slope.

The compare-equals-ceiling case is run twice, once with a tick on every cycle and once with a tick on every other cycle:
- Merging the two cases would either toggle the output where it must stay silent, or leave the output silent where a full-period pulse is required.

High time and period are measured at all three resolutions and in both polarities. This catches a wrong ceiling, a swapped polarity, and compare bits that escape the resolution mask.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // Channel output behaviour selected by the 2-bit mode field
    typedef enum logic [1:0] {
        PWM_OFF     = 2'b00,
        PWM_OFF_ALT = 2'b01,
        PWM_NORM    = 2'b10,
        PWM_INV     = 2'b11
    } pwm_mode_e;

    // Resolution select encoding
    typedef enum logic [1:0] {
        RES_8   = 2'b00,
        RES_9   = 2'b01,
        RES_10  = 2'b10,
        RES_10B = 2'b11
    } pwm_res_e;

endpackage

// File: rtl/pwm_updown_counter.sv
// Up/down ramp counter shared by all PWM channels.
// Counts 0 -> top -> 0 on each cycle where tick is high.
// Also exposes the value it is about to take (cnt_nxt), the direction of
// that step, and whether that step lands on the ceiling.
// Assumes: res_sel may change at any time. If the count is above the new
// ceiling, the next tick pulls it back to the ceiling.
module pwm_updown_counter
    import pwm_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int MIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       res_sel,
    output logic [CNT_W-1:0] cnt_q,
    output logic             down_q,
    output logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             moving_up,
    output logic             arrive_top
);
    localparam logic [CNT_W-1:0] TOP_LO  = CNT_W'((1 << MIN_W) - 1);
    localparam logic [CNT_W-1:0] TOP_MID = CNT_W'((1 << (MIN_W + 1)) - 1);
    localparam logic [CNT_W-1:0] TOP_HI  = {CNT_W{1'b1}};

    logic down_nxt;

    // Ceiling value from the resolution select
    always_comb begin
        unique case (pwm_res_e'(res_sel))
            RES_8:   top = TOP_LO;
            RES_9:   top = TOP_MID;
            default: top = TOP_HI;
        endcase
    end

    // Next count value and direction for the next tick
    always_comb begin
        moving_up = !down_q;
        if (!down_q) begin
            if (cnt_q >= top) cnt_nxt = top;
            else              cnt_nxt = cnt_q + 1'b1;
            down_nxt = (cnt_nxt == top);
        end else begin
            if (cnt_q > top)  cnt_nxt = top;
            else              cnt_nxt = cnt_q - 1'b1;
            down_nxt = (cnt_nxt != '0);
        end
        arrive_top = tick && (cnt_nxt == top);
    end

    // Counter and direction registers, advanced only on a tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
        end else if (tick) begin
            cnt_q  <= cnt_nxt;
            down_q <= down_nxt;
        end
    end

    assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(cnt_q) && $stable(down_q)));

    assert_turn_at_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !down_q && ((cnt_q + 1'b1) == top)) |=> (down_q && cnt_q == $past(top)));

    assert_turn_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && down_q && cnt_q == CNT_W'(1)) |=> (!down_q && cnt_q == '0));

    assert_top_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (top == TOP_LO) || (top == TOP_MID) || (top == TOP_HI));

endmodule

// File: rtl/pwm_cmp_channel.sv
// One compare channel.
// Holds a buffered compare value, which becomes active when the counter
// arrives at the ceiling. Sets or clears its waveform register on compare
// matches according to the mode and the direction of the counter.
// Assumes: cnt_nxt, moving_up and arrive_top come from the shared counter
// and describe the step taken on the current tick. The output register
// therefore changes in the same cycle as the count.
module pwm_cmp_channel
    import pwm_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             prescaled,
    input  logic [1:0]       mode,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] top,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic             moving_up,
    input  logic             arrive_top,
    output logic             pwm,
    output logic             oe
);
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] act_q;
    logic [CNT_W-1:0] cmp_eff;
    logic             wave_q;
    logic             pend_q;
    logic             connected;
    logic             inv;
    logic             hit;
    logic             top_hit;
    pwm_mode_e        mode_e;

    // Decode of the mode field
    always_comb begin
        mode_e    = pwm_mode_e'(mode);
        connected = (mode_e == PWM_NORM) || (mode_e == PWM_INV);
        inv       = (mode_e == PWM_INV);
    end

    // Compare value in use this tick, masked to the resolution
    always_comb begin
        cmp_eff = (arrive_top ? hold_q : act_q) & top;
        hit     = tick && (cnt_nxt == cmp_eff);
        top_hit = hit && arrive_top;
    end

    // Holding register takes every software write
    always_ff @(posedge clk) begin
        if (!rst_n)  hold_q <= '0;
        else if (wr) hold_q <= wdata;
    end

    // Active compare is reloaded only when the counter reaches the ceiling
    always_ff @(posedge clk) begin
        if (!rst_n)          act_q <= '0;
        else if (arrive_top) act_q <= hold_q;
    end

    // Waveform register and the alternation flag for compare at the ceiling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (!connected) begin
            wave_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (top_hit) begin
            if (!prescaled) begin
                pend_q <= 1'b0;
            end else if (!pend_q) begin
                wave_q <= inv;
                pend_q <= 1'b1;
            end else begin
                wave_q <= !inv;
                pend_q <= 1'b0;
            end
        end else if (hit) begin
            wave_q <= moving_up ? inv : !inv;
        end
    end

    assign pwm = wave_q;
    assign oe  = connected;

    assert_load_only_at_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q != $past(act_q)) |-> $past(arrive_top));

    assert_top_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (connected && top_hit && !prescaled) |=> $stable(wave_q));

    assert_noninv_up_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == PWM_NORM && hit && !arrive_top && moving_up) |=> !wave_q);

    assert_inv_down_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == PWM_INV && hit && !arrive_top && !moving_up) |=> !wave_q);

    assert_disconnected_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !connected |=> !pwm);

endmodule

// File: rtl/dual_pwm_timer.sv
// Dual-channel phase-correct PWM timer.
// One shared up/down counter drives N_CH compare channels, which a
// generate loop instantiates. Channel 0 is brought out as A, channel 1 as B.
// Assumes: cnt_tick comes from an external prescaler, and prescaled tells
// whether that prescaler divides the clock (it matters only when a compare
// value equals the ceiling).
module dual_pwm_timer
    import pwm_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int MIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_tick,
    input  logic             prescaled,
    input  logic [1:0]       res_sel,
    input  logic [1:0]       mode_a,
    input  logic [1:0]       mode_b,
    input  logic             wr_a,
    input  logic             wr_b,
    input  logic [CNT_W-1:0] data_a,
    input  logic [CNT_W-1:0] data_b,
    output logic             pwm_a,
    output logic             pwm_b,
    output logic             oe_a,
    output logic             oe_b,
    output logic [CNT_W-1:0] count,
    output logic             counting_down
);
    localparam int N_CH = 2;

    logic [CNT_W-1:0] top;
    logic [CNT_W-1:0] cnt_nxt;
    logic             moving_up;
    logic             arrive_top;

    logic [1:0]       mode_v [N_CH];
    logic             wr_v   [N_CH];
    logic [CNT_W-1:0] data_v [N_CH];
    logic             pwm_v  [N_CH];
    logic             oe_v   [N_CH];

    // Gather per-channel inputs into arrays
    always_comb begin
        mode_v[0] = mode_a;  mode_v[1] = mode_b;
        wr_v[0]   = wr_a;    wr_v[1]   = wr_b;
        data_v[0] = data_a;  data_v[1] = data_b;
    end

    pwm_updown_counter #(
        .CNT_W(CNT_W),
        .MIN_W(MIN_W)
    ) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cnt_tick),
        .res_sel   (res_sel),
        .cnt_q     (count),
        .down_q    (counting_down),
        .top       (top),
        .cnt_nxt   (cnt_nxt),
        .moving_up (moving_up),
        .arrive_top(arrive_top)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        pwm_cmp_channel #(
            .CNT_W(CNT_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (cnt_tick),
            .prescaled (prescaled),
            .mode      (mode_v[g]),
            .wr        (wr_v[g]),
            .wdata     (data_v[g]),
            .top       (top),
            .cnt_nxt   (cnt_nxt),
            .moving_up (moving_up),
            .arrive_top(arrive_top),
            .pwm       (pwm_v[g]),
            .oe        (oe_v[g])
        );
    end

    assign pwm_a = pwm_v[0];
    assign pwm_b = pwm_v[1];
    assign oe_a  = oe_v[0];
    assign oe_b  = oe_v[1];

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !counting_down && !pwm_a && !pwm_b));

    assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(res_sel) && $past(count) <= $past(top) |-> count <= top);

endmodule

// File: tb/dual_pwm_timer_test.sv
`timescale 1ns/1ps
module dual_pwm_timer_test;
    localparam int CNT_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cnt_tick;
    logic             prescaled = 1'b0;
    logic [1:0]       res_sel = 2'b00;
    logic [1:0]       mode_a = 2'b00;
    logic [1:0]       mode_b = 2'b00;
    logic             wr_a = 1'b0;
    logic             wr_b = 1'b0;
    logic [CNT_W-1:0] data_a = '0;
    logic [CNT_W-1:0] data_b = '0;
    logic             pwm_a, pwm_b, oe_a, oe_b, counting_down;
    logic [CNT_W-1:0] count;

    int checks = 0;
    int failures = 0;
    int tick_div = 0;

    dual_pwm_timer #(.CNT_W(CNT_W), .MIN_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .prescaled(prescaled),
        .res_sel(res_sel), .mode_a(mode_a), .mode_b(mode_b),
        .wr_a(wr_a), .wr_b(wr_b), .data_a(data_a), .data_b(data_b),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .oe_a(oe_a), .oe_b(oe_b),
        .count(count), .counting_down(counting_down)
    );

    always #2 clk = ~clk;

    // Prescaler model: a tick every tick_div cycles, none when tick_div is 0
    initial begin
        int ph;
        ph = 0;
        cnt_tick = 1'b0;
        forever begin
            @(negedge clk);
            if (tick_div <= 0) begin
                cnt_tick <= 1'b0;
                ph = 0;
            end else begin
                cnt_tick <= (ph == 0);
                ph = (ph + 1) % tick_div;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic pwm_of(input int ch);
        return (ch == 0) ? pwm_a : pwm_b;
    endfunction

    task automatic setup(input logic [1:0] r, input logic [1:0] ma, input logic [1:0] mb,
                         input logic [CNT_W-1:0] da, input logic [CNT_W-1:0] db,
                         input int div, input logic pre);
        tick_div = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        res_sel = r; mode_a = ma; mode_b = mb; prescaled = pre;
        rst_n = 1'b1;
        @(negedge clk);
        wr_a = 1'b1; wr_b = 1'b1; data_a = da; data_b = db;
        @(negedge clk);
        wr_a = 1'b0; wr_b = 1'b0;
        tick_div = div;
    endtask

    task automatic write_cmp(input int ch, input logic [CNT_W-1:0] d);
        @(negedge clk);
        if (ch == 0) begin wr_a = 1'b1; data_a = d; end
        else         begin wr_b = 1'b1; data_b = d; end
        @(negedge clk);
        wr_a = 1'b0; wr_b = 1'b0;
    endtask

    task automatic wait_cnt(input int v, input logic dn);
        do @(negedge clk); while (!(count == CNT_W'(v) && counting_down == dn));
    endtask

    // Period and high time in cycles, measured from one rising edge to the next
    task automatic measure(input int ch, output int period, output int high);
        logic prev, cur;
        prev = pwm_of(ch);
        forever begin
            @(negedge clk);
            cur = pwm_of(ch);
            if (!prev && cur) break;
            prev = cur;
        end
        period = 0; high = 0; prev = cur;
        forever begin
            period++;
            if (cur) high++;
            @(negedge clk);
            cur = pwm_of(ch);
            if (!prev && cur) break;
            prev = cur;
        end
    endtask

    task automatic measure_steady(input int ch, output int period, output int high);
        int p0, h0;
        measure(ch, p0, h0);
        measure(ch, period, high);
    endtask

    task automatic t_reset;
        setup(2'b00, 2'b10, 2'b11, 10'd100, 10'd100, 1, 1'b0);
        repeat (300) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "count after reset", int'(count), 0);
        check("R1", "direction after reset", int'(counting_down), 0);
        check("R1", "pwm_a after reset", int'(pwm_a), 0);
        check("R1", "pwm_b after reset", int'(pwm_b), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_ramp;
        int v;
        setup(2'b00, 2'b00, 2'b00, '0, '0, 1, 1'b0);
        do @(negedge clk); while (!counting_down);
        check("R2", "8-bit turning value", int'(count), 255);
        @(negedge clk);
        check("R3", "first value on descent", int'(count), 254);
        do @(negedge clk); while (counting_down);
        check("R3", "bottom value", int'(count), 0);
        tick_div = 0;
        repeat (2) @(negedge clk);
        v = int'(count);
        repeat (10) @(negedge clk);
        check("R4", "count frozen without tick", int'(count), v);
        setup(2'b11, 2'b00, 2'b00, '0, '0, 1, 1'b0);
        do @(negedge clk); while (!counting_down);
        check("R2", "res 11 turning value", int'(count), 1023);
    endtask

    task automatic t_two_channels;
        int p, h;
        setup(2'b00, 2'b10, 2'b11, 10'd100, 10'd60, 1, 1'b0);
        measure_steady(0, p, h);
        check("R6", "A non-inverted period", p, 510);
        check("R6", "A non-inverted high", h, 200);
        measure_steady(1, p, h);
        check("R12", "B inverted period", p, 510);
        check("R12", "B inverted high", h, 390);
    endtask

    task automatic t_inverted_9bit;
        int p, h;
        setup(2'b01, 2'b11, 2'b00, 10'd300, '0, 1, 1'b0);
        measure_steady(0, p, h);
        check("R7", "9-bit inverted period", p, 1022);
        check("R7", "9-bit inverted high", h, 422);
    endtask

    task automatic t_noninv_10bit;
        int p, h;
        setup(2'b10, 2'b00, 2'b10, '0, 10'd1000, 1, 1'b0);
        measure_steady(1, p, h);
        check("R2", "10-bit period", p, 2046);
        check("R6", "10-bit non-inverted high", h, 2000);
    endtask

    task automatic t_disconnected;
        int highs_a, highs_b;
        setup(2'b00, 2'b01, 2'b10, 10'd100, 10'd100, 1, 1'b0);
        highs_a = 0; highs_b = 0;
        for (int i = 0; i < 1100; i++) begin
            @(negedge clk);
            if (pwm_a) highs_a++;
            if (pwm_b) highs_b++;
        end
        check("R5", "disconnected A high samples", highs_a, 0);
        check("R5", "disconnected A oe", int'(oe_a), 0);
        check("R5", "connected B oe", int'(oe_b), 1);
        check("R5", "connected B toggles", int'(highs_b > 0), 1);
    endtask

    task automatic t_buffered_write;
        setup(2'b00, 2'b10, 2'b00, 10'd100, '0, 1, 1'b0);
        repeat (1100) @(negedge clk);
        wait_cnt(50, 1'b0);
        write_cmp(0, 10'd200);
        wait_cnt(150, 1'b0);
        check("R8", "old compare still active on rise", int'(pwm_a), 0);
        wait_cnt(180, 1'b1);
        check("R8", "new compare active after ceiling", int'(pwm_a), 1);
    endtask

    task automatic t_top_no_prescale;
        int edges;
        logic prev;
        setup(2'b00, 2'b10, 2'b00, 10'd255, '0, 1, 1'b0);
        repeat (600) @(negedge clk);
        edges = 0;
        prev = pwm_a;
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            if (pwm_a != prev) edges++;
            prev = pwm_a;
        end
        check("R9", "edges with compare at ceiling", edges, 0);
    endtask

    task automatic t_top_prescale;
        int p, h;
        setup(2'b00, 2'b10, 2'b00, 10'd255, '0, 2, 1'b1);
        measure_steady(0, p, h);
        check("R10", "full-period pulse period", p, 2040);
        check("R10", "full-period pulse high", h, 1020);
    endtask

    task automatic t_mask;
        int p, h;
        setup(2'b00, 2'b10, 2'b00, 10'h164, '0, 1, 1'b0);
        measure_steady(0, p, h);
        check("R11", "8-bit masked period", p, 510);
        check("R11", "8-bit masked high", h, 200);
        setup(2'b01, 2'b10, 2'b00, 10'h3F0, '0, 1, 1'b0);
        measure_steady(0, p, h);
        check("R11", "9-bit masked period", p, 1022);
        check("R11", "9-bit masked high", h, 992);
    endtask

    initial begin
        t_reset();
        t_ramp();
        t_two_channels();
        t_inverted_9bit();
        t_noninv_10bit();
        t_disconnected();
        t_buffered_write();
        t_top_no_prescale();
        t_top_prescale();
        t_mask();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule